// File: doc/BRIEF.md
# Serial Command Register Bridge

This block sits between a byte-wide serial receiver/transmitter pair and a counter-mode cipher engine. Each byte arriving from the receiver is parsed as part of a small command protocol. A command byte names a target register in its upper four bits and the kind of access in its lower four bits. A write command takes the next byte as its payload. A read command returns one byte to the transmitter.

Key, nonce and input-block registers are wider than a byte. They are filled one byte per write, and a per-register byte pointer picks the slot. Repeating one command address therefore streams a whole key, nonce or block through the link. The output block is captured from the engine and drained one byte per read. A status bit is polled to find out when a fresh output block is waiting. A control register issues one-cycle reset and start pulses to the engine and holds one configuration level.

The serial frame format is 8-bit: a low start bit, eight data bits with the least-significant bit first, and a high stop level. Serialisation and deserialisation happen outside this block, which sees only whole bytes with valid/ready handshakes.

Top module: `serial_reg_bridge`

## Requirements
- R1: Sixteen writes of command 0x11 fill the 128-bit key. The first payload byte lands in bits [127:120] and each following byte lands in the next lower byte.
- R2: Twelve writes of command 0x21 fill the 96-bit nonce in the same most-significant-first order.
- R3: Sixteen writes of command 0x31 fill the 128-bit input block in the same most-significant-first order.
- R4: After the last byte of a wide register is written, its pointer wraps. The next write replaces the most significant byte again.
- R5: Writing a control payload with bit 0 set does four things. It clears every byte pointer and the output-valid bit, clears control bit 1, and drives eng_reset high for exactly one cycle.
- R6: Control payload bit 2 drives eng_start high for exactly one cycle and reads back as 0. Bit 1 is stored, drives eng_init, and reads back as written.
- R7: Command 0x00 returns the status byte. In it, bit 3 is output-valid, bit 1 is the stored configuration bit, and all other bits are 0.
- R8: An eng_dout_valid pulse captures eng_dout, resets the read pointer and sets output-valid. Each 0x40 read returns the next byte, most significant first. Output-valid clears when the last byte has been read.
- R9: A command byte is ignored and consumes no payload byte in any of these cases: the upper nibble is 5 or more, the lower nibble is 2 or more, or the byte is 0x41.
- R10: Reads of 0x10, 0x20 and 0x30 return 0x00 and do not move any pointer.
- R11: While a response byte is pending, rx_ready is low. tx_valid and tx_data then stay stable until tx_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Bridge can take a received byte |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the response byte |
| eng_key | output | 8*KEY_BYTES | Key to the engine |
| eng_nonce | output | 8*NONCE_BYTES | Nonce to the engine |
| eng_din | output | 8*BLK_BYTES | Input block to the engine |
| eng_init | output | 1 | Stored configuration level (control bit 1) |
| eng_start | output | 1 | One-cycle start pulse |
| eng_reset | output | 1 | One-cycle engine reset pulse |
| eng_dout | input | 8*BLK_BYTES | Output block from the engine |
| eng_dout_valid | input | 1 | Capture strobe for eng_dout |

## Verification
The bench builds the bridge with its default sizes: a 16-byte key, a 12-byte nonce and 16-byte blocks. At these sizes the command values, byte orders and wrap points are exactly those of the protocol. A full fill followed by one extra write reaches the pointer wrap of each register in a few hundred cycles. Random payloads and random ignored command bytes are mixed into the streams, so a parser that swallowed a payload shows up as a misplaced byte. A control reset issued in the middle of a block drain brings the pointer-clear path within reach for the read side as well as the write side.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    PS_CMD  = 2'd0,
    PS_DATA = 2'd1,
    PS_SEND = 2'd2
  } parse_state_t;

  typedef enum logic [2:0] {
    TG_CTRL  = 3'd0,
    TG_KEY   = 3'd1,
    TG_NONCE = 3'd2,
    TG_DIN   = 3'd3,
    TG_DOUT  = 3'd4
  } target_t;

  localparam logic [3:0] OP_READ  = 4'h0;
  localparam logic [3:0] OP_WRITE = 4'h1;

  localparam int CTL_RESET_BIT = 0;
  localparam int CTL_INIT_BIT  = 1;
  localparam int CTL_START_BIT = 2;
  localparam int STS_VALID_BIT = 3;

endpackage

// File: rtl/bridge_wreg.sv
module bridge_wreg #(
  parameter int BYTES = 16,
  localparam int W  = 8 * BYTES,
  localparam int PW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [7:0]   wr_byte,
  output logic [W-1:0] q
);

  localparam logic [PW-1:0] LAST = PW'(BYTES - 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [W-1:0]  val_d;
  logic          en;

  assign en = clr | wr_en;

  always_comb begin
    val_d = q;
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (wr_en) begin
      for (int i = 0; i < BYTES; i++) begin
        if (ptr_q == PW'(i)) val_d[W-8-8*i +: 8] = wr_byte;
      end
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      ptr_q <= '0;
    end else if (en) begin
      q     <= val_d;
      ptr_q <= ptr_d;
    end
  end

  AST_WR_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && ptr_q == LAST) |=> (ptr_q == '0)); // R4

  AST_WR_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R10

endmodule

// File: rtl/bridge_rblk.sv
module bridge_rblk #(
  parameter int BYTES = 16,
  localparam int W  = 8 * BYTES,
  localparam int PW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rd_en,
  output logic [7:0]   rd_byte,
  output logic         valid
);

  localparam logic [PW-1:0] LAST = PW'(BYTES - 1);

  logic [W-1:0]  blk_q, blk_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          valid_d;
  logic          en;

  assign en = clr | load | rd_en;

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (ptr_q == PW'(i)) rd_byte = blk_q[W-8-8*i +: 8];
    end
  end

  always_comb begin
    blk_d   = blk_q;
    ptr_d   = ptr_q;
    valid_d = valid;
    if (clr) begin
      ptr_d   = '0;
      valid_d = 1'b0;
    end else if (load) begin
      blk_d   = load_data;
      ptr_d   = '0;
      valid_d = 1'b1;
    end else if (rd_en) begin
      if (ptr_q == LAST) begin
        ptr_d   = '0;
        valid_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      ptr_q <= '0;
      valid <= 1'b0;
    end else if (en) begin
      blk_q <= blk_d;
      ptr_q <= ptr_d;
      valid <= valid_d;
    end
  end

  AST_VALID_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !load && !clr && ptr_q == LAST) |=> !valid); // R8

  AST_VALID_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (valid && ptr_q == '0)); // R8

  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!valid && ptr_q == '0)); // R5

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       ptr_clr,
  output logic       init,
  output logic       start,
  output logic       reset_pulse
);

  logic init_d, start_d, reset_d;

  assign ptr_clr = wr_en & wr_byte[CTL_RESET_BIT];

  always_comb begin
    init_d  = init;
    start_d = 1'b0;
    reset_d = 1'b0;
    if (wr_en) begin
      init_d  = wr_byte[CTL_INIT_BIT] & ~wr_byte[CTL_RESET_BIT];
      start_d = wr_byte[CTL_START_BIT];
      reset_d = wr_byte[CTL_RESET_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init        <= 1'b0;
      start       <= 1'b0;
      reset_pulse <= 1'b0;
    end else begin
      start       <= start_d;
      reset_pulse <= reset_d;
      if (wr_en) init <= init_d;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_en) |=> !start); // R6

  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_pulse && !wr_en) |=> !reset_pulse); // R5

  AST_RESET_DROPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte[CTL_RESET_BIT]) |=> (!init && reset_pulse)); // R5

endmodule

// File: rtl/bridge_parser.sv
module bridge_parser
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic [7:0] status_byte,
  input  logic [7:0] dout_byte,
  output logic       ctrl_wr,
  output logic       key_wr,
  output logic       nonce_wr,
  output logic       din_wr,
  output logic       dout_rd,
  output logic [7:0] wr_byte
);

  parse_state_t state_q, state_d;
  target_t      tgt_q, tgt_d;
  logic [7:0]   tx_d;
  logic         take;
  logic [3:0]   hi, lo;

  assign rx_ready = (state_q != PS_SEND);
  assign tx_valid = (state_q == PS_SEND);
  assign take     = rx_valid & rx_ready;
  assign hi       = rx_data[7:4];
  assign lo       = rx_data[3:0];
  assign wr_byte  = rx_data;

  always_comb begin
    state_d  = state_q;
    tgt_d    = tgt_q;
    tx_d     = tx_data;
    ctrl_wr  = 1'b0;
    key_wr   = 1'b0;
    nonce_wr = 1'b0;
    din_wr   = 1'b0;
    dout_rd  = 1'b0;
    unique case (state_q)
      PS_CMD: begin
        if (take) begin
          if (lo == OP_WRITE && hi <= 4'd3) begin
            state_d = PS_DATA;
            tgt_d   = target_t'(hi[2:0]);
          end else if (lo == OP_READ && hi <= 4'd4) begin
            state_d = PS_SEND;
            if (hi == 4'd0)      tx_d = status_byte;
            else if (hi == 4'd4) tx_d = dout_byte;
            else                 tx_d = 8'h00;
            dout_rd = (hi == 4'd4);
          end
        end
      end
      PS_DATA: begin
        if (take) begin
          state_d = PS_CMD;
          unique case (tgt_q)
            TG_CTRL:  ctrl_wr  = 1'b1;
            TG_KEY:   key_wr   = 1'b1;
            TG_NONCE: nonce_wr = 1'b1;
            TG_DIN:   din_wr   = 1'b1;
            default:  ;
          endcase
        end
      end
      PS_SEND: begin
        if (tx_ready) state_d = PS_CMD;
      end
      default: state_d = PS_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_CMD;
      tgt_q   <= TG_CTRL;
      tx_data <= '0;
    end else begin
      state_q <= state_d;
      if (take && state_q == PS_CMD) begin
        tgt_q   <= tgt_d;
        tx_data <= tx_d;
      end
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R11

  AST_NO_RX_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, key_wr, nonce_wr, din_wr, dout_rd})); // R9

endmodule

// File: rtl/serial_reg_bridge.sv
module serial_reg_bridge
  import bridge_pkg::*;
#(
  parameter int KEY_BYTES   = 16,
  parameter int NONCE_BYTES = 12,
  parameter int BLK_BYTES   = 16,
  localparam int KW = 8 * KEY_BYTES,
  localparam int NW = 8 * NONCE_BYTES,
  localparam int BW = 8 * BLK_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic [KW-1:0] eng_key,
  output logic [NW-1:0] eng_nonce,
  output logic [BW-1:0] eng_din,
  output logic          eng_init,
  output logic          eng_start,
  output logic          eng_reset,
  input  logic [BW-1:0] eng_dout,
  input  logic          eng_dout_valid
);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic       ctrl_wr, key_wr, nonce_wr, din_wr, dout_rd;
  logic [7:0] wr_byte, dout_byte, status_byte;
  logic       ptr_clr, out_valid;

  always_comb begin
    status_byte                = '0;
    status_byte[STS_VALID_BIT] = out_valid;
    status_byte[CTL_INIT_BIT]  = eng_init;
  end

  bridge_parser u_parser (
    .clk(clk), .rst_n(rst_int_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .status_byte(status_byte), .dout_byte(dout_byte),
    .ctrl_wr(ctrl_wr), .key_wr(key_wr), .nonce_wr(nonce_wr),
    .din_wr(din_wr), .dout_rd(dout_rd), .wr_byte(wr_byte)
  );

  bridge_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(ctrl_wr), .wr_byte(wr_byte),
    .ptr_clr(ptr_clr), .init(eng_init),
    .start(eng_start), .reset_pulse(eng_reset)
  );

  bridge_wreg #(.BYTES(KEY_BYTES)) u_key (
    .clk(clk), .rst_n(rst_int_n), .clr(ptr_clr),
    .wr_en(key_wr), .wr_byte(wr_byte), .q(eng_key)
  );

  bridge_wreg #(.BYTES(NONCE_BYTES)) u_nonce (
    .clk(clk), .rst_n(rst_int_n), .clr(ptr_clr),
    .wr_en(nonce_wr), .wr_byte(wr_byte), .q(eng_nonce)
  );

  bridge_wreg #(.BYTES(BLK_BYTES)) u_din (
    .clk(clk), .rst_n(rst_int_n), .clr(ptr_clr),
    .wr_en(din_wr), .wr_byte(wr_byte), .q(eng_din)
  );

  bridge_rblk #(.BYTES(BLK_BYTES)) u_dout (
    .clk(clk), .rst_n(rst_int_n), .clr(ptr_clr),
    .load(eng_dout_valid), .load_data(eng_dout),
    .rd_en(dout_rd), .rd_byte(dout_byte), .valid(out_valid)
  );

endmodule

// File: tb/test_serial_reg_bridge.sv
module test_serial_reg_bridge;

  localparam int KB = 16;
  localparam int NB = 12;
  localparam int BB = 16;

  logic            clk, rst_n;
  logic            rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0]      rx_data, tx_data;
  logic [8*KB-1:0] eng_key;
  logic [8*NB-1:0] eng_nonce;
  logic [8*BB-1:0] eng_din, eng_dout;
  logic            eng_init, eng_start, eng_reset, eng_dout_valid;

  serial_reg_bridge #(.KEY_BYTES(KB), .NONCE_BYTES(NB), .BLK_BYTES(BB)) i_serial_reg_bridge (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .eng_key(eng_key), .eng_nonce(eng_nonce), .eng_din(eng_din),
    .eng_init(eng_init), .eng_start(eng_start), .eng_reset(eng_reset),
    .eng_dout(eng_dout), .eng_dout_valid(eng_dout_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input bit valid, input bit init);
    return {4'b0000, valid, 1'b0, init, 1'b0};
  endfunction

  function automatic logic [7:0] junk_cmd(input int sel);
    case (sel % 4)
      0:       return 8'h55;
      1:       return 8'h12;
      2:       return 8'h41;
      default: return 8'hF3;
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_cmd(input logic [7:0] cmd, output logic [7:0] b);
    send_byte(cmd);
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    check(!rx_ready, "R11 rx_ready low while response pending", 128'(rx_ready), 128'(0));
    @(negedge clk);
    check(tx_valid && tx_data == b, "R11 response held without tx_ready", 128'(tx_data), 128'(b));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    logic [8*KB-1:0] kexp;
    logic [8*NB-1:0] nexp;
    logic [8*BB-1:0] dexp, blk;
    logic [7:0]      b, r;
    process::self().srandom(32'd20240611);
    rx_valid = 0; rx_data = 0; tx_ready = 0;
    eng_dout = '0; eng_dout_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    check(!tx_valid && rx_ready && eng_key == '0 && !eng_start && !eng_reset,
          "R11 reset state", 128'(tx_valid), 128'(0));

    // R1: key fill, most significant byte first
    kexp = '0;
    for (int i = 0; i < KB; i++) begin
      b = 8'($urandom);
      send_byte(8'h11); send_byte(b);
      kexp[8*KB-8-8*i +: 8] = b;
    end
    check(eng_key == kexp, "R1 key fill", eng_key, kexp);

    // R2 + R9: nonce fill with ignored command bytes interleaved
    nexp = '0;
    for (int i = 0; i < NB; i++) begin
      b = 8'($urandom);
      if (($urandom % 2) == 0) send_byte(junk_cmd(int'($urandom % 4)));
      send_byte(8'h21); send_byte(b);
      nexp[8*NB-8-8*i +: 8] = b;
    end
    check(eng_nonce == nexp, "R2 nonce fill", 128'(eng_nonce), 128'(nexp));
    check(eng_key == kexp, "R9 ignored commands leave key unchanged", eng_key, kexp);

    // R3: input block fill
    dexp = '0;
    for (int i = 0; i < BB; i++) begin
      b = 8'($urandom);
      send_byte(8'h31); send_byte(b);
      dexp[8*BB-8-8*i +: 8] = b;
    end
    check(eng_din == dexp, "R3 input block fill", eng_din, dexp);

    // R4: wrap after last byte
    send_byte(8'h11); send_byte(8'hA5);
    kexp[8*KB-1 -: 8] = 8'hA5;
    check(eng_key == kexp, "R4 key pointer wrap", eng_key, kexp);

    // R10: read of write-only register returns 0 and keeps pointer
    read_cmd(8'h10, r);
    check(r == 8'h00, "R10 read of key returns zero", 128'(r), 128'(0));
    send_byte(8'h11); send_byte(8'h3C);
    kexp[8*KB-9 -: 8] = 8'h3C;
    check(eng_key == kexp, "R10 key pointer unmoved by read", eng_key, kexp);

    // R9: ignored command followed directly by a payload-looking byte
    send_byte(8'h41); send_byte(8'h31); send_byte(8'h77);
    dexp[8*BB-1 -: 8] = 8'h77;
    check(eng_din == dexp, "R9 ignored 0x41 consumes no payload", eng_din, dexp);

    // R6 + R7: stored bit and status
    send_byte(8'h01); send_byte(8'h02);
    check(eng_init == 1'b1, "R6 init bit stored", 128'(eng_init), 128'(1));
    read_cmd(8'h00, r);
    check(r == status_exp(0, 1), "R7 status with init", 128'(r), 128'(status_exp(0, 1)));

    // R6: start pulse
    send_byte(8'h01); send_byte(8'h06);
    check(eng_start == 1'b1, "R6 start pulse high", 128'(eng_start), 128'(1));
    @(negedge clk);
    check(eng_start == 1'b0, "R6 start pulse one cycle", 128'(eng_start), 128'(0));
    read_cmd(8'h00, r);
    check(r == status_exp(0, 1), "R6 start reads back 0", 128'(r), 128'(status_exp(0, 1)));

    // R5: control reset
    send_byte(8'h01); send_byte(8'h01);
    check(eng_reset == 1'b1 && eng_init == 1'b0, "R5 reset pulse and init cleared",
          128'({eng_reset, eng_init}), 128'(2'b10));
    @(negedge clk);
    check(eng_reset == 1'b0, "R5 reset pulse one cycle", 128'(eng_reset), 128'(0));
    send_byte(8'h11); send_byte(8'hE1);
    kexp[8*KB-1 -: 8] = 8'hE1;
    check(eng_key == kexp, "R5 key pointer cleared", eng_key, kexp);
    send_byte(8'h21); send_byte(8'hD2);
    nexp[8*NB-1 -: 8] = 8'hD2;
    check(eng_nonce == nexp, "R5 nonce pointer cleared", 128'(eng_nonce), 128'(nexp));

    // R8: output blocks drained in order
    for (int k = 0; k < 2; k++) begin
      blk = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      eng_dout = blk; eng_dout_valid = 1'b1;
      @(negedge clk);
      eng_dout_valid = 1'b0;
      read_cmd(8'h00, r);
      check(r == status_exp(1, 0), "R8 valid set on capture", 128'(r), 128'(status_exp(1, 0)));
      for (int i = 0; i < BB; i++) begin
        read_cmd(8'h40, r);
        check(r == blk[8*BB-8-8*i +: 8], "R8 output byte order", 128'(r), 128'(blk[8*BB-8-8*i +: 8]));
      end
      read_cmd(8'h00, r);
      check(r == status_exp(0, 0), "R8 valid cleared after drain", 128'(r), 128'(status_exp(0, 0)));
    end

    // R5: control reset in the middle of a drain
    blk = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    eng_dout = blk; eng_dout_valid = 1'b1;
    @(negedge clk);
    eng_dout_valid = 1'b0;
    for (int i = 0; i < 3; i++) read_cmd(8'h40, r);
    send_byte(8'h01); send_byte(8'h01);
    read_cmd(8'h00, r);
    check(r == status_exp(0, 0), "R5 reset clears valid", 128'(r), 128'(status_exp(0, 0)));
    read_cmd(8'h40, r);
    check(r == blk[8*BB-1 -: 8], "R5 read pointer cleared", 128'(r), 128'(blk[8*BB-1 -: 8]));

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule